// File: doc/BRIEF.md
# Four-Channel PWM Digital-to-Analog Output

This block drives four open-drain pins. Each pin can carry an 8-bit pulse-width-modulated waveform that becomes an analog level after an external RC filter. Each pin can instead carry the value of a plain output latch. A shared timebase divides the core clock by a prescale factor and steps a 256-position phase counter, so one PWM period takes `256 * PRESCALE` clock cycles. With a 4.5 MHz clock and a prescale of 2, the repetition rate is about 8.79 kHz.

A duty value arrives on a valid/ready write port and lands in the addressed channel's shadow register. The shadow is copied into the channel's compare register only when the phase counter wraps to zero. A waveform already in progress therefore always completes with its old duty. A per-pin mode register selects between PWM and the latch. A clock-stop input freezes the timebase, releases every pin and stalls the write port.

The port pins are modelled with logic 0 meaning the transistor pulls low and logic 1 meaning released (high through the external pull-up). Back-pressure rule: a duty write is taken on a rising clock edge when both `duty_valid` and `duty_ready` are high. `duty_ready` is low during reset and while `clk_stop` is high. A source holding `duty_valid` must keep the channel and data stable until that edge.

Top module: `pwm_dac_top`

## Requirements
- R1: After reset all pins read 1, every pin is in latch mode (mode bit 0), every latch bit is 1, and every shadow and compare duty is 0.
- R2: The phase counter advances once every PRESCALE clocks through 0..255 and wraps to 0. A PWM-mode pin is 0 while the counter is below the channel's compare duty, so it is low for duty*PRESCALE cycles of every 256*PRESCALE-cycle period.
- R3: A write is accepted when `duty_valid` and `duty_ready` are both high, and it stores `duty_data` in the shadow register of channel `duty_chan` (binary index 0..3). The shadow register changes at no other time.
- R4: The compare duty takes the shadow value only on the clock where the counter wraps from 255 to 0. A write in mid-period leaves the current waveform unchanged until the period ends.
- R5: A compare duty of 0 keeps a PWM-mode pin at 1 for the whole period. A duty of 255 gives exactly PRESCALE high cycles per period.
- R6: Mode register bit i set to 1 selects PWM for pin i, and 0 selects the latch. A write of the mode register (`mode_we`) takes effect on the pin one clock later, using the compare duty already held, with no wait for a period boundary.
- R7: In latch mode pin i shows latch bit i, written with `latch_we`/`latch_d`. Latch writes have no effect on pins in PWM mode.
- R8: While `clk_stop` is high, all pins read 1 from the next clock on and the phase counter holds its value. Writes offered during the stop are not taken. When `clk_stop` falls, the counter resumes from the held phase.
- R9: Pins are registered. Each pin reflects the counter, compare duty, mode and latch state as held before the preceding clock edge.
- R10: `duty_ready` is high exactly when reset is released and `clk_stop` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_stop | input | 1 | Freezes the timebase, releases all pins, stalls writes |
| duty_valid | input | 1 | Duty write offered |
| duty_ready | output | 1 | Duty write can be taken |
| duty_chan | input | 2 | Channel index of the duty write |
| duty_data | input | 8 | Duty value, low-time in counter steps |
| mode_we | input | 1 | Load the per-pin mode register |
| mode_d | input | 4 | New mode bits (1 = PWM, 0 = latch) |
| latch_we | input | 1 | Load the output latch |
| latch_d | input | 4 | New latch bits |
| dac_pin | output | 4 | Pin states, 0 = pulled low, 1 = released |

## Verification
If the phase counter is wrong or drifts, the low-time of every PWM pin shifts within one period (512 cycles by default). A per-period low-cycle count exposes this, as does a cycle-by-cycle comparison against a reference model. If the shadow-to-compare transfer happens at the wrong moment, a mid-period write changes the waveform before the 255-to-0 wrap instead of after it, and the first mismatching cycle falls inside the same period. A mode or latch register error shows on the pin on the next clock. A stop that does not freeze the counter shows as a phase offset after resume.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

  // Source selected for one pin
  typedef enum logic {
    PIN_LATCH = 1'b0,
    PIN_PWM   = 1'b1
  } pin_src_e;

  // Level on a released open-drain pin
  localparam logic PIN_RELEASED = 1'b1;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int DUTY_W   = 8,
  parameter int PRESCALE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  output logic [DUTY_W-1:0] phase,
  output logic              wrap
);

  localparam logic [DUTY_W-1:0] PHASE_LAST = '1;

  logic              step;
  logic [DUTY_W-1:0] phase_q;

  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] DIV_LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_q <= '0;
        end else if (!halt) begin
          div_q <= (div_q == DIV_LAST) ? '0 : div_q + PW'(1);
        end
      end

      assign step = !halt && (div_q == DIV_LAST);
    end else begin : g_nodiv
      assign step = !halt;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (step) begin
      phase_q <= phase_q + DUTY_W'(1);
    end
  end

  assign phase = phase_q;
  assign wrap  = step && (phase_q == PHASE_LAST);

  AST_HALT_FREEZES_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(phase)); // R8
  AST_WRAP_LANDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (phase == '0)); // R2

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DUTY_W-1:0] load_val,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] phase,
  output logic              pull_low
);

  logic [DUTY_W-1:0] shadow_q;
  logic [DUTY_W-1:0] compare_q;

  // Shadow takes accepted writes at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (load_en) begin
      shadow_q <= load_val;
    end
  end

  // Compare register swaps only at the period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      compare_q <= '0;
    end else if (wrap) begin
      compare_q <= shadow_q;
    end
  end

  assign pull_low = (phase < compare_q);

  AST_COMPARE_SWAPS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(compare_q)); // R4
  AST_SHADOW_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(shadow_q)); // R3

endmodule

// File: rtl/pwm_pin_mux.sv
module pwm_pin_mux
  import pwm_dac_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              mode_we,
  input  logic [NUM_CH-1:0] mode_d,
  input  logic              latch_we,
  input  logic [NUM_CH-1:0] latch_d,
  input  logic [NUM_CH-1:0] pull_low,
  output logic [NUM_CH-1:0] pin
);

  logic [NUM_CH-1:0] mode_q;
  logic [NUM_CH-1:0] latch_q;
  logic [NUM_CH-1:0] pin_d;
  logic [NUM_CH-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= {NUM_CH{PIN_LATCH}};
      latch_q <= {NUM_CH{PIN_RELEASED}};
    end else begin
      if (mode_we)  mode_q  <= mode_d;
      if (latch_we) latch_q <= latch_d;
    end
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_pin
      always_comb begin
        if (halt) begin
          pin_d[i] = PIN_RELEASED;
        end else if (pin_src_e'(mode_q[i]) == PIN_PWM) begin
          pin_d[i] = !pull_low[i];
        end else begin
          pin_d[i] = latch_q[i];
        end
      end

      AST_LATCH_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && (pin_src_e'(mode_q[i]) == PIN_LATCH)) |=> (pin[i] == $past(latch_q[i]))); // R7
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= {NUM_CH{PIN_RELEASED}};
    end else begin
      pin_q <= pin_d;
    end
  end

  assign pin = pin_q;

  AST_STOP_RELEASES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (&pin)); // R8

endmodule

// File: rtl/pwm_dac_top.sv
module pwm_dac_top #(
  parameter int NUM_CH   = 4,
  parameter int DUTY_W   = 8,
  parameter int PRESCALE = 2
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         clk_stop,
  input  logic                                         duty_valid,
  output logic                                         duty_ready,
  input  logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] duty_chan,
  input  logic [DUTY_W-1:0]                            duty_data,
  input  logic                                         mode_we,
  input  logic [NUM_CH-1:0]                            mode_d,
  input  logic                                         latch_we,
  input  logic [NUM_CH-1:0]                            latch_d,
  output logic [NUM_CH-1:0]                            dac_pin
);

  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [DUTY_W-1:0] phase;
  logic              wrap;
  logic              take;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] pull_low;

  assign duty_ready = rst_n && !clk_stop;
  assign take       = duty_valid && duty_ready;

  pwm_timebase #(
    .DUTY_W   (DUTY_W),
    .PRESCALE (PRESCALE)
  ) u_timebase (
    .clk   (clk),
    .rst_n (rst_n),
    .halt  (clk_stop),
    .phase (phase),
    .wrap  (wrap)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign hit[i] = take && (duty_chan == CH_IDX_W'(i));

      pwm_channel #(
        .DUTY_W (DUTY_W)
      ) u_channel (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (hit[i]),
        .load_val (duty_data),
        .wrap     (wrap),
        .phase    (phase),
        .pull_low (pull_low[i])
      );
    end
  endgenerate

  pwm_pin_mux #(
    .NUM_CH (NUM_CH)
  ) u_pin_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (clk_stop),
    .mode_we  (mode_we),
    .mode_d   (mode_d),
    .latch_we (latch_we),
    .latch_d  (latch_d),
    .pull_low (pull_low),
    .pin      (dac_pin)
  );

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R3

endmodule

// File: tb/pwm_dac_top_tb_top.sv
`timescale 1ns/1ps
module pwm_dac_top_tb_top;

  localparam int NCH    = 4;
  localparam int DW     = 8;
  localparam int PS     = 2;
  localparam int PERIOD = 256 * PS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_stop = 1'b0;
  logic          duty_valid = 1'b0;
  logic          duty_ready;
  logic [1:0]    duty_chan = '0;
  logic [DW-1:0] duty_data = '0;
  logic          mode_we = 1'b0;
  logic [NCH-1:0] mode_d = '0;
  logic          latch_we = 1'b0;
  logic [NCH-1:0] latch_d = '0;
  logic [NCH-1:0] dac_pin;

  always #2 clk = ~clk;

  pwm_dac_top #(.NUM_CH(NCH), .DUTY_W(DW), .PRESCALE(PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_stop(clk_stop),
    .duty_valid(duty_valid), .duty_ready(duty_ready),
    .duty_chan(duty_chan), .duty_data(duty_data),
    .mode_we(mode_we), .mode_d(mode_d),
    .latch_we(latch_we), .latch_d(latch_d),
    .dac_pin(dac_pin)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  logic [NCH-1:0] exp_q[$];
  string          tag_q[$];

  // Reference model built from the requirements
  int             m_div;
  logic [DW-1:0]  m_phase;
  logic [DW-1:0]  m_shadow[NCH];
  logic [DW-1:0]  m_cmp[NCH];
  logic [NCH-1:0] m_mode;
  logic [NCH-1:0] m_latch;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_phase = '0; m_mode = '0; m_latch = '1;
      for (int i = 0; i < NCH; i++) begin m_shadow[i] = '0; m_cmp[i] = '0; end
    end else begin
      logic [NCH-1:0] e;
      for (int i = 0; i < NCH; i++) begin
        if (clk_stop)       e[i] = 1'b1;
        else if (m_mode[i]) e[i] = !(m_phase < m_cmp[i]);
        else                e[i] = m_latch[i];
      end
      exp_q.push_back(e);
      tag_q.push_back(cur_req);
      if (!clk_stop) begin
        if (m_div == PS - 1) begin
          m_div = 0;
          if (m_phase == 8'hFF)
            for (int i = 0; i < NCH; i++) m_cmp[i] = m_shadow[i];
          m_phase = m_phase + 8'd1;
        end else begin
          m_div = m_div + 1;
        end
        if (duty_valid) m_shadow[duty_chan] = duty_data;
      end
      if (mode_we)  m_mode  = mode_d;
      if (latch_we) m_latch = latch_d;
    end
  end

  // Monitor: pops one expected pin vector per cycle
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10", {31'd0, duty_ready}, {31'd0, !clk_stop});
      if (exp_q.size() > 0) begin
        logic [NCH-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {28'd0, dac_pin}, {28'd0, e});
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_duty(int ch, int val);
    @(posedge clk); #1;
    duty_valid = 1'b1; duty_chan = 2'(ch); duty_data = 8'(val);
    @(posedge clk); #1;
    duty_valid = 1'b0;
  endtask

  task automatic set_mode(logic [NCH-1:0] v);
    @(posedge clk); #1;
    mode_we = 1'b1; mode_d = v;
    @(posedge clk); #1;
    mode_we = 1'b0;
  endtask

  task automatic set_latch(logic [NCH-1:0] v);
    @(posedge clk); #1;
    latch_we = 1'b1; latch_d = v;
    @(posedge clk); #1;
    latch_we = 1'b0;
  endtask

  task automatic measure_low(int ch, int expv, string req);
    int lows = 0;
    repeat (PERIOD) begin
      @(negedge clk);
      if (dac_pin[ch] == 1'b0) lows++;
    end
    check(req, 32'(lows), 32'(expv));
  endtask

  bit done = 0;

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1", {28'd0, dac_pin}, 32'hF);     // R1: released after reset
    check("R10", {31'd0, duty_ready}, 32'd0); // R10: not ready in reset
    @(posedge clk); #1;
    rst_n = 1'b1;

    cur_req = "R1";  idle(10);
    cur_req = "R7";  set_latch(4'b0101); idle(10);
    cur_req = "R9";  set_latch(4'b1010); idle(6);

    cur_req = "R3";
    write_duty(0, 64); write_duty(1, 0); write_duty(2, 255); write_duty(3, 128);
    idle(5);
    cur_req = "R6";  set_mode(4'b1111); idle(2 * PERIOD);

    cur_req = "R2";
    measure_low(0, 64 * PS, "R2");
    measure_low(3, 128 * PS, "R2");
    measure_low(1, 0, "R5");                  // R5: zero duty stays high
    measure_low(2, PERIOD - PS, "R5");        // R5: full-scale duty

    cur_req = "R4";
    idle(37); write_duty(0, 200); idle(2 * PERIOD);
    measure_low(0, 200 * PS, "R4");

    cur_req = "R7";  set_latch(4'b0000); idle(100);
    cur_req = "R6";  set_mode(4'b0111); idle(50); set_mode(4'b1111); idle(50);

    cur_req = "R8";
    @(posedge clk); #1; clk_stop = 1'b1;
    idle(3);
    @(negedge clk);
    check("R8", {28'd0, dac_pin}, 32'hF);
    write_duty(1, 50);                        // R8: offered but not taken
    idle(90);
    @(posedge clk); #1; clk_stop = 1'b0;
    idle(2 * PERIOD);
    measure_low(1, 0, "R8");
    idle(5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule